// File: doc/BRIEF.md
# Direction-Qualified Trigger Rate Divider

This block sits between a PWM timer's event logic and an ADC, and it thins out the stream of conversion trigger pulses. Each channel takes a one-cycle raw trigger, the timer's present count direction and a flag that says whether the timer runs center-aligned. A two-bit phase selector decides which half of a center-aligned period may contribute events. A five-bit divide value N then lets one of every N+1 surviving events through as a one-cycle output pulse.

Channels are fully independent: each has its own phase selector, divide value, direction input and mode flag. The divider restarts whenever its channel's divide value or phase selector changes, so the first qualified event under a new setting always produces a pulse.

Top module: `trig_postscaler`

## Requirements
- R1: In center-aligned mode (ctr_center=1) with phase selector 2'b00, events pass whether ctr_down is 0 (counting up) or 1 (counting down).
- R2: In center-aligned mode with phase selector 2'b01, only events with ctr_down=1 qualify; events with ctr_down=0 never cause a pulse.
- R3: In center-aligned mode with phase selector 2'b10, only events with ctr_down=0 qualify; events with ctr_down=1 never cause a pulse.
- R4: Phase selector 2'b11 behaves exactly like 2'b00.
- R5: With ctr_center=0 every event qualifies, whatever the phase selector and ctr_down.
- R6: With divide value N, the first qualified event after reset pulses and after that exactly one of every N+1 qualified events pulses; unqualified events and idle cycles do not advance the count.
- R7: Divide value 0 passes every qualified event.
- R8: The output pulse appears in the cycle after the qualifying event, lasts one cycle per event, and never appears without an event on that channel the cycle before.
- R9: A change of a channel's divide value or phase selector restarts its count, so the next qualified event pulses and counting continues with the new setting.
- R10: A qualified event arriving in the same cycle as a setting change pulses, and the count that follows uses the new divide value.
- R11: Each channel counts and filters only with its own inputs; activity on one channel does not alter another's output.
- R12: While rst is high and in the cycle after, trig_out is all zero and every count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NCH | Raw one-cycle trigger per channel |
| ctr_down | input | NCH | Timer count direction per channel, 1 = counting down |
| ctr_center | input | NCH | 1 = timer in center-aligned mode |
| phase_sel | input | 2*NCH | Phase selector per channel, channel i at bits [2i+1:2i] |
| div_val | input | PSC_W*NCH | Divide value N per channel, channel i at bits [PSC_W*i +: PSC_W] |
| trig_out | output | NCH | Decimated one-cycle trigger per channel |

## Verification
The restart on a setting change and the counting of a qualified event can land in the same cycle. The bench provokes this by writing a new divide value or phase selector on the very clock edge that carries a qualified event, partway through a count that would otherwise have suppressed that event. It judges the outcome by requiring a pulse on that event and then a gap matching the new divide value before the next pulse; a checker property also demands the pulse whenever the divide value differs from its previous-cycle value alongside an event.

// File: rtl/trig_postscaler_pkg.sv
package trig_postscaler_pkg;

    localparam int unsigned DEF_NCH   = 2;
    localparam int unsigned DEF_PSC_W = 5;

    typedef enum logic [1:0] {
        PH_ANY  = 2'b00,
        PH_DOWN = 2'b01,
        PH_UP   = 2'b10,
        PH_RSVD = 2'b11
    } phase_e;

    typedef struct packed {
        logic   center;
        logic   down;
        phase_e phase;
    } qual_ctx_t;

    function automatic logic phase_pass(input qual_ctx_t ctx);
        logic ok;
        if (!ctx.center) begin
            ok = 1'b1;
        end else begin
            case (ctx.phase)
                PH_DOWN: ok = ctx.down;
                PH_UP:   ok = !ctx.down;
                default: ok = 1'b1;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/trig_phase_gate.sv
module trig_phase_gate
    import trig_postscaler_pkg::*;
(
    input  logic       evt,
    input  logic       down,
    input  logic       center,
    input  logic [1:0] phase,
    output logic       qual
);
    qual_ctx_t ctx;

    always_comb begin
        ctx.center = center;
        ctx.down   = down;
        ctx.phase  = phase_e'(phase);
        qual       = evt && phase_pass(ctx);
    end
endmodule

// File: rtl/trig_decimator.sv
module trig_decimator #(
    parameter int unsigned PSC_W = 5,
    parameter int unsigned CFG_W = PSC_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qual,
    input  logic [PSC_W-1:0] scale,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             pulse
);
    logic [CFG_W-1:0] cfg_q;
    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] cnt_eff;
    logic             restart;
    logic             fire;
    logic             pulse_q;

    always_comb begin
        restart = (cfg_word != cfg_q);
        cnt_eff = restart ? '0 : cnt_q;
        fire    = qual && (cnt_eff == '0);
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_word;
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
            if (qual) begin
                cnt_q <= fire ? scale : (cnt_eff - 1'b1);
            end else begin
                cnt_q <= cnt_eff;
            end
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/trig_postscale_chan.sv
module trig_postscale_chan #(
    parameter int unsigned PSC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             down,
    input  logic             center,
    input  logic [1:0]       phase,
    input  logic [PSC_W-1:0] scale,
    output logic             trig
);
    localparam int unsigned CFG_W = PSC_W + 2;

    logic             qual;
    logic [CFG_W-1:0] cfg_word;

    assign cfg_word = {phase, scale};

    trig_phase_gate gate_i (
        .evt    (evt),
        .down   (down),
        .center (center),
        .phase  (phase),
        .qual   (qual)
    );

    trig_decimator #(
        .PSC_W (PSC_W),
        .CFG_W (CFG_W)
    ) dec_i (
        .clk      (clk),
        .rst      (rst),
        .qual     (qual),
        .scale    (scale),
        .cfg_word (cfg_word),
        .pulse    (trig)
    );
endmodule

// File: rtl/trig_postscaler.sv
module trig_postscaler
    import trig_postscaler_pkg::*;
#(
    parameter int unsigned NCH   = DEF_NCH,
    parameter int unsigned PSC_W = DEF_PSC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       evt_in,
    input  logic [NCH-1:0]       ctr_down,
    input  logic [NCH-1:0]       ctr_center,
    input  logic [2*NCH-1:0]     phase_sel,
    input  logic [PSC_W*NCH-1:0] div_val,
    output logic [NCH-1:0]       trig_out
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        trig_postscale_chan #(
            .PSC_W (PSC_W)
        ) chan_i (
            .clk    (clk),
            .rst    (rst),
            .evt    (evt_in[g]),
            .down   (ctr_down[g]),
            .center (ctr_center[g]),
            .phase  (phase_sel[2*g +: 2]),
            .scale  (div_val[PSC_W*g +: PSC_W]),
            .trig   (trig_out[g])
        );
    end
endmodule

// File: rtl/trig_postscaler_chk.sv
module trig_postscaler_chk #(
    parameter int unsigned NCH   = 2,
    parameter int unsigned PSC_W = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCH-1:0]       evt_in,
    input logic [NCH-1:0]       ctr_down,
    input logic [NCH-1:0]       ctr_center,
    input logic [2*NCH-1:0]     phase_sel,
    input logic [PSC_W*NCH-1:0] div_val,
    input logic [NCH-1:0]       trig_out
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
            trig_out[g] |-> $past(evt_in[g])); // R8

        AST_DOWN_PHASE_BLOCKS_UP: assert property (@(posedge clk) disable iff (rst)
            (evt_in[g] && ctr_center[g] && phase_sel[2*g +: 2] == 2'b01 && !ctr_down[g])
            |=> !trig_out[g]); // R2

        AST_UP_PHASE_BLOCKS_DOWN: assert property (@(posedge clk) disable iff (rst)
            (evt_in[g] && ctr_center[g] && phase_sel[2*g +: 2] == 2'b10 && ctr_down[g])
            |=> !trig_out[g]); // R3

        AST_ZERO_DIV_PASSES: assert property (@(posedge clk) disable iff (rst)
            (evt_in[g] && !ctr_center[g] && div_val[PSC_W*g +: PSC_W] == '0)
            |=> trig_out[g]); // R7

        AST_RESTART_ON_COLLISION: assert property (@(posedge clk) disable iff (rst)
            (evt_in[g] && !ctr_center[g]
             && div_val[PSC_W*g +: PSC_W] != $past(div_val[PSC_W*g +: PSC_W]))
            |=> trig_out[g]); // R10
    end
endmodule

bind trig_postscaler trig_postscaler_chk #(
    .NCH   (NCH),
    .PSC_W (PSC_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .evt_in     (evt_in),
    .ctr_down   (ctr_down),
    .ctr_center (ctr_center),
    .phase_sel  (phase_sel),
    .div_val    (div_val),
    .trig_out   (trig_out)
);

// File: tb/trig_postscaler_tb_top.sv
module trig_postscaler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int PSC_W = 5;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCH-1:0]       evt_in = '0;
    logic [NCH-1:0]       ctr_down = '0;
    logic [NCH-1:0]       ctr_center = '0;
    logic [2*NCH-1:0]     phase_sel = '0;
    logic [PSC_W*NCH-1:0] div_val = '0;
    logic [NCH-1:0]       trig_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_postscaler #(.NCH(NCH), .PSC_W(PSC_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .evt_in     (evt_in),
        .ctr_down   (ctr_down),
        .ctr_center (ctr_center),
        .phase_sel  (phase_sel),
        .div_val    (div_val),
        .trig_out   (trig_out)
    );

    task automatic chk(input logic [NCH-1:0] exp, input string tag);
        checks++;
        if (trig_out !== exp) begin
            failures++;
            $display("FAIL %s: trig_out actual=%b expected=%b", tag, trig_out, exp);
        end
    endtask

    // At a negedge: drive events, wait one cycle, check registered output.
    task automatic step(input logic [NCH-1:0] ev, input logic [NCH-1:0] exp, input string tag);
        evt_in = ev;
        @(negedge clk);
        chk(exp, tag);
        evt_in = '0;
    endtask

    task automatic set_ch0(input logic ctr, input logic [1:0] ph, input int n);
        ctr_center[0] = ctr;
        phase_sel[1:0] = ph;
        div_val[PSC_W-1:0] = PSC_W'(n);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        evt_in = 2'b11;
        repeat (2) @(negedge clk);
        chk(2'b00, "R12 output low in reset");
        evt_in = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(2'b00, "R12 output low after reset");
    endtask

    task automatic t_divide;
        set_ch0(1'b0, 2'b00, 2);
        step(2'b00, 2'b00, "R9 idle after config");
        step(2'b01, 2'b01, "R6 first event pulses");
        step(2'b01, 2'b00, "R6 second suppressed");
        step(2'b00, 2'b00, "R6 idle no advance");
        step(2'b01, 2'b00, "R6 third suppressed");
        step(2'b01, 2'b01, "R6 fourth pulses");
        step(2'b01, 2'b00, "R6 fifth suppressed");
        step(2'b01, 2'b00, "R6 sixth suppressed");
        step(2'b01, 2'b01, "R6 seventh pulses");
        // unqualified events must not advance
        set_ch0(1'b1, 2'b01, 2);
        step(2'b00, 2'b00, "R9 idle after phase change");
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R2 down event pulses");
        ctr_down[0] = 1'b0; step(2'b01, 2'b00, "R2 up blocked");
        ctr_down[0] = 1'b0; step(2'b01, 2'b00, "R6 up blocked no advance");
        ctr_down[0] = 1'b1; step(2'b01, 2'b00, "R6 down counted");
        ctr_down[0] = 1'b1; step(2'b01, 2'b00, "R6 down counted 2");
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R6 down third pulses");
    endtask

    task automatic t_zero;
        set_ch0(1'b0, 2'b00, 0);
        step(2'b00, 2'b00, "R8 idle");
        for (int k = 0; k < 4; k++) step(2'b01, 2'b01, "R7 every event passes");
        step(2'b00, 2'b00, "R8 single cycle after last event");
    endtask

    task automatic t_phase;
        set_ch0(1'b1, 2'b00, 0);
        ctr_down[0] = 1'b0; step(2'b01, 2'b01, "R1 up passes");
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R1 down passes");
        set_ch0(1'b1, 2'b01, 0);
        ctr_down[0] = 1'b0; step(2'b01, 2'b00, "R2 up blocked");
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R2 down passes");
        set_ch0(1'b1, 2'b10, 0);
        ctr_down[0] = 1'b1; step(2'b01, 2'b00, "R3 down blocked");
        ctr_down[0] = 1'b0; step(2'b01, 2'b01, "R3 up passes");
        set_ch0(1'b1, 2'b11, 0);
        ctr_down[0] = 1'b0; step(2'b01, 2'b01, "R4 up passes");
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R4 down passes");
        set_ch0(1'b0, 2'b01, 0);
        ctr_down[0] = 1'b0; step(2'b01, 2'b01, "R5 linear up passes");
        set_ch0(1'b0, 2'b10, 0);
        ctr_down[0] = 1'b1; step(2'b01, 2'b01, "R5 linear down passes");
    endtask

    task automatic t_restart;
        set_ch0(1'b0, 2'b00, 3);
        step(2'b00, 2'b00, "R9 idle");
        step(2'b01, 2'b01, "R9 first pulses");
        step(2'b01, 2'b00, "R9 second suppressed");
        set_ch0(1'b0, 2'b00, 1);
        step(2'b00, 2'b00, "R9 change without event");
        step(2'b01, 2'b01, "R9 restart pulses");
        step(2'b01, 2'b00, "R9 new divide suppresses");
        step(2'b01, 2'b01, "R9 new divide pulses");
    endtask

    task automatic t_collide;
        set_ch0(1'b0, 2'b00, 3);
        step(2'b00, 2'b00, "R10 idle");
        step(2'b01, 2'b01, "R10 first pulses");
        step(2'b01, 2'b00, "R10 second suppressed");
        set_ch0(1'b0, 2'b00, 2);
        step(2'b01, 2'b01, "R10 event on divide change pulses");
        step(2'b01, 2'b00, "R10 new count 1");
        step(2'b01, 2'b00, "R10 new count 2");
        step(2'b01, 2'b01, "R10 new count pulses");
        step(2'b01, 2'b00, "R10 suppressed again");
        set_ch0(1'b1, 2'b10, 2);
        ctr_down[0] = 1'b0;
        step(2'b01, 2'b01, "R9 event on phase change pulses");
    endtask

    task automatic t_indep;
        set_ch0(1'b0, 2'b00, 1);
        ctr_center[1] = 1'b0;
        phase_sel[3:2] = 2'b00;
        div_val[2*PSC_W-1:PSC_W] = '0;
        step(2'b00, 2'b00, "R11 idle");
        step(2'b11, 2'b11, "R11 both first");
        step(2'b11, 2'b10, "R11 ch0 suppressed ch1 passes");
        step(2'b11, 2'b11, "R11 both pulse");
        step(2'b10, 2'b10, "R11 ch1 only");
        step(2'b01, 2'b00, "R11 ch0 unaffected by ch1");
        step(2'b01, 2'b01, "R11 ch0 pulses");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_divide();
        t_zero();
        t_phase();
        t_restart();
        t_collide();
        t_indep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule